// File: doc/BRIEF.md
# Four-Source Interrupt Merger with Fixed Vector

This block gathers four interrupt sources for a small processor core: a rising edge on an external pin, a timer overflow pulse, a level change on any of four port pins, and a data-memory write-complete pulse. Each source has its own pending flag and its own mask bit. A global enable gates the request sent to the CPU. A separate wake output ignores the global enable, so a sleeping core can be woken by any unmasked pending flag.

Software reads and writes the flags and masks through a small register bus. The CPU accepts a request only at an instruction-cycle boundary, which is marked by a strobe. When it accepts, the block clears the global enable and presents the fixed handler address. A return strobe sets the global enable again. A pending flag stays set until software clears it, so an uncleared source raises the request again as soon as the enable returns.

The external pin and the port pins are asynchronous. Each passes through a two-stage synchronizer before detection, which fixes the event-to-flag delay at three clock edges.

Top module: `irq_merge`

## Requirements
- R1: After reset the flags, the masks and the global enable read as zero, and irq_req and wake are low.
- R2: Flag bit positions are: bit 0 for the external pin, bit 1 for the timer, bit 2 for port change, and bit 3 for write-complete. Each source sets its flag even when its mask or the global enable is clear. A tmr_ovf or mem_wr_done pulse shows in the flag after one clock edge.
- R3: irq_req is high exactly when the global enable is set and at least one flag has its mask bit set.
- R4: wake is high exactly when at least one flag has its mask bit set, whatever the global enable holds.
- R5: A rising edge on ext_pin sets flag bit 0 on the third rising clock edge after the pin changes. A falling edge sets nothing.
- R6: A change in either direction on any port_pins bit sets flag bit 2 on the third rising clock edge after the change.
- R7: An acknowledge is accepted only when cpu_ack, cyc_strobe and irq_req are all high. After the next edge the global enable is clear, and vec_valid is high for one cycle with vec_addr equal to 0x004.
- R8: cpu_ack while cyc_strobe is low has no effect: vec_valid stays low and the global enable is unchanged.
- R9: A reti pulse sets the global enable. A flag that is still pending then raises irq_req again.
- R10: A flag is cleared only by a software write. If a source event and a software write that clears that flag fall in the same cycle, the flag ends up set.
- R11: Register address 0 holds the flags in bits 3:0. Address 1 holds the masks in bits 3:0 and the global enable in bit 4. A write takes effect on the next edge, and rd_data returns the register that rd_addr selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| port_pins | input | PORT_N | Asynchronous watched port pins |
| mem_wr_done | input | 1 | Data-memory write-complete pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register write select |
| wr_data | input | 5 | Register write data |
| rd_addr | input | 1 | Register read select |
| rd_data | output | 5 | Register read data |
| cyc_strobe | input | 1 | Instruction-cycle boundary marker |
| cpu_ack | input | 1 | CPU accepts the request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Wake-from-sleep request |
| vec_valid | output | 1 | Vector presented, one cycle |
| vec_addr | output | VEC_W | Fixed handler address |

## Verification
Any fault in the flag, mask or enable registers shows at the register bus read on the next cycle. It also shows on irq_req and wake in the same cycle, because both are driven straight from those registers. A wrong synchronizer depth or a wrong edge detector moves the flag away from the third edge after a pin change, so the bench samples one edge before that point and on it. A fault in the acknowledge path appears one edge after the strobe, either as a missing or extra vec_valid pulse or as a global enable that does not clear.

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int VEC_W = 13,
  parameter logic [VEC_W-1:0] VECTOR = 13'h004,
  parameter int PORT_N = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              tmr_ovf,
  input  logic [PORT_N-1:0] port_pins,
  input  logic              mem_wr_done,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [4:0]        wr_data,
  input  logic              rd_addr,
  output logic [4:0]        rd_data,
  input  logic              cyc_strobe,
  input  logic              cpu_ack,
  input  logic              reti,
  output logic              irq_req,
  output logic              wake,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_addr
);

  logic [SYNC_N-1:0] ext_sync;
  logic              ext_last;
  logic [PORT_N-1:0] port_sync [SYNC_N];
  logic [PORT_N-1:0] port_last;
  logic [3:0]        flags, en;
  logic              gie;

  wire ext_s      = ext_sync[SYNC_N-1];
  wire ext_rise   = ext_s & ~ext_last;
  wire port_chg   = |(port_sync[SYNC_N-1] ^ port_last);
  wire [3:0] hw_set = {mem_wr_done, port_chg, tmr_ovf, ext_rise};
  wire sw_flag_wr = wr_en & ~wr_addr;
  wire sw_en_wr   = wr_en & wr_addr;
  wire pending    = |(flags & en);
  wire accept     = cpu_ack & cyc_strobe & irq_req;

  assign irq_req  = gie & pending;
  assign wake     = pending;
  assign vec_addr = VECTOR;
  assign rd_data  = rd_addr ? {gie, en} : {1'b0, flags};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync  <= '0;
      ext_last  <= 1'b0;
      port_last <= '0;
      for (int i = 0; i < SYNC_N; i++) port_sync[i] <= '0;
    end else begin
      ext_sync  <= {ext_sync[SYNC_N-2:0], ext_pin};
      ext_last  <= ext_s;
      port_sync[0] <= port_pins;
      for (int i = 1; i < SYNC_N; i++) port_sync[i] <= port_sync[i-1];
      port_last <= port_sync[SYNC_N-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      en        <= '0;
      gie       <= 1'b0;
      vec_valid <= 1'b0;
    end else begin
      flags     <= (sw_flag_wr ? wr_data[3:0] : flags) | hw_set;
      if (sw_en_wr) en <= wr_data[3:0];
      if (accept)        gie <= 1'b0;
      else if (reti)     gie <= 1'b1;
      else if (sw_en_wr) gie <= wr_data[4];
      vec_valid <= accept;
    end
  end

  // R2
  tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> flags[1]);

  // R4
  wake_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!gie && vec_valid));

  // R8
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> !vec_valid);

  // R9
  reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !accept) |=> gie);

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_flag_wr |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: tb/test_irq_merge.sv
module test_irq_merge;
  logic clk = 0, rst_n = 0;
  logic ext_pin = 0, tmr_ovf = 0, mem_wr_done = 0;
  logic [3:0] port_pins = '0;
  logic wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic cyc_strobe = 0, cpu_ack = 0, reti = 0;
  logic irq_req, wake, vec_valid;
  logic [12:0] vec_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_merge i_irq_merge (.*);

  // {flags[3:0], en[3:0], gie, exp_irq, exp_wake}
  localparam logic [10:0] VECS [8] = '{
    {4'b0001, 4'b0001, 1'b1, 1'b1, 1'b1},
    {4'b0001, 4'b0010, 1'b1, 1'b0, 1'b0},
    {4'b1000, 4'b1000, 1'b0, 1'b0, 1'b1},
    {4'b0110, 4'b0100, 1'b1, 1'b1, 1'b1},
    {4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0},
    {4'b0000, 4'b1111, 1'b1, 1'b0, 1'b0},
    {4'b1010, 4'b0101, 1'b1, 1'b0, 1'b0},
    {4'b0010, 4'b1011, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [4:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic a, output logic [4:0] d);
    rd_addr = a; #1 d = rd_data;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [4:0] d;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 flags", d, 0);
    rd(1, d); chk("R1 enables", d, 0);
    chk("R1 irq", irq_req, 0);
    chk("R1 wake", wake, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R11 vector table
    foreach (VECS[i]) begin
      wr(0, {1'b0, VECS[i][10:7]});
      wr(1, {VECS[i][2], VECS[i][6:3]});
      rd(0, d); chk("R11 flag readback", d, {1'b0, VECS[i][10:7]});
      chk("R3 irq", irq_req, VECS[i][1]);
      chk("R4 wake", wake, VECS[i][0]);
    end
    wr(1, 5'b0); wr(0, 5'b0);

    // R2 timer and write-complete with masks off
    tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
    rd(0, d); chk("R2 timer flag", d, 5'b00010);
    mem_wr_done = 1; @(negedge clk); mem_wr_done = 0;
    rd(0, d); chk("R2 write-complete flag", d, 5'b01010);
    chk("R2 no irq when masked", irq_req, 0);
    wr(0, 5'b0);

    // R5 external rising edge latency
    ext_pin = 1;
    @(negedge clk); @(negedge clk);
    rd(0, d); chk("R5 before third edge", d, 0);
    @(negedge clk);
    rd(0, d); chk("R5 on third edge", d, 5'b00001);
    wr(0, 5'b0);
    ext_pin = 0;
    repeat (5) @(negedge clk);
    rd(0, d); chk("R5 falling edge ignored", d, 0);

    // R6 port change both directions
    port_pins = 4'b0100;
    @(negedge clk); @(negedge clk);
    rd(0, d); chk("R6 before third edge", d, 0);
    @(negedge clk);
    rd(0, d); chk("R6 rise change", d, 5'b00100);
    wr(0, 5'b0);
    repeat (4) @(negedge clk);
    port_pins = 4'b0000;
    repeat (3) @(negedge clk);
    rd(0, d); chk("R6 fall change", d, 5'b00100);
    wr(0, 5'b0);

    // R10 set wins over clear
    wr(0, 5'b00010);
    tmr_ovf = 1; wr(0, 5'b0); tmr_ovf = 0;
    rd(0, d); chk("R10 set wins", d, 5'b00010);
    repeat (3) @(negedge clk);
    rd(0, d); chk("R10 flag holds", d, 5'b00010);

    // R8 ack without strobe
    wr(1, 5'b10010);
    chk("R3 irq raised", irq_req, 1);
    cpu_ack = 1; cyc_strobe = 0;
    @(negedge clk);
    chk("R8 no vector", vec_valid, 0);
    rd(1, d); chk("R8 gie kept", d, 5'b10010);

    // R7 accepted acknowledge
    cyc_strobe = 1;
    @(negedge clk);
    cpu_ack = 0; cyc_strobe = 0;
    chk("R7 vec_valid", vec_valid, 1);
    chk("R7 vec_addr", vec_addr, 13'h004);
    rd(1, d); chk("R7 gie cleared", d, 5'b00010);
    chk("R7 irq dropped", irq_req, 0);
    chk("R4 wake without gie", wake, 1);
    @(negedge clk);
    chk("R7 single pulse", vec_valid, 0);

    // R9 return re-enables, flag still pending
    reti = 1; @(negedge clk); reti = 0;
    rd(1, d); chk("R9 gie set", d, 5'b10010);
    chk("R9 re-request", irq_req, 1);

    done = 1;
    summary();
  end
endmodule